// File: doc/BRIEF.md
# Master/Slave SPI Serial Port

This block is an 8-bit synchronous serial port that can act either as the clock-driving master or as a slave following an external clock. Each transfer shifts a byte out and a byte in at the same time through one shift register. Software reaches the port through a small register interface. It writes the byte to send into a data buffer, reads back the byte that came in, and sets the role, the clock source, the idle clock level, the data-launch edge and the input sample point in a control register. Three sticky status flags report a waiting byte, a write collision and a receive overflow.

As master, the port produces the serial clock itself. It divides the system clock by 4, 8, 16 or 64, or it runs at half the rate of an external timer tick. As slave, it brings the external serial clock, the data input and the active-low select through two-flop synchronisers and steps on the edges it detects. The select input can be honoured or ignored. While the select is honoured and high, the port does not drive its data output.

Top module: `spi_port`

## Requirements
- R1: Register map. Address 0 is the data buffer: a write queues the byte to send and a read returns the last received byte. Address 1 is control, read/write, with bit 0 enable, bits 4:1 mode, bit 5 idle clock level, bit 6 launch-edge select and bit 7 late sample. Address 2 is status: bit 0 buffer full, bit 1 write collision, bit 2 overflow. Any write to address 2 clears bits 1 and 2. Every register resets to zero.
- R2: Mode codes 0000, 1010, 0001 and 0010 select master with a system clock divide of 4, 8, 16 and 64. This gives half clock periods of 2, 4, 8 and 32 cycles. In these modes the first clock edge appears one half period after the buffer write. Completion, with buffer full set, follows 17 half periods after the write.
- R3: Mode code 0011 selects master clocked from the timer tick input. The serial clock changes level only on every second one-cycle tick pulse and stays still without pulses.
- R4: A transfer moves exactly 8 bits, most significant bit first, out on the data output and in from the data input at once. On completion the received byte goes into the buffer and buffer full is set.
- R5: When no master transfer is running, the serial clock output rests at the idle level from control bit 5. With control bit 6 set, each bit is put on the output before its leading edge (the edge leaving the idle level). With bit 6 clear, each bit is put on the output at its leading edge. A receiver sampling on the opposite edge sees the byte in order.
- R6: In master mode, late sample clear captures input at the middle of each output bit. Late sample set captures it at the end of that bit. When a slave changes its data at leading edges, a middle capture gets the byte shifted right by one with a leading 0, and an end capture gets the byte unchanged.
- R7: Reading the buffer at address 0 clears buffer full.
- R8: A buffer write while a transfer is in progress sets write collision. That write leaves the running transfer and its outgoing byte unchanged.
- R9: If a transfer completes while buffer full is still set, overflow is set and the unread byte stays in the buffer.
- R10: Mode codes 0100 and 0101 select slave mode. The port steps on synchronised edges of the external clock, using the same launch and sample edges as in R5. It completes on the 16th edge, loading the buffer and setting buffer full.
- R11: In mode 0100, while the select input is high, the port leaves its data output undriven and ignores clock edges. In mode 0101 the select input is ignored and the output stays driven.
- R12: With enable clear or a mode code not listed above, no clock or data output is driven and a buffer write starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears buffer full on address 0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from the address |
| tmr_tick | input | 1 | One-cycle timer pulse for the timer clock source |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Active-low slave select |

## Verification
In master mode the register path adds one cycle. The first clock edge therefore shows up exactly one half period after the cycle that takes the buffer write, and buffer full rises after seventeen half periods. The bench counts falling clock edges from the write and compares both counts with those figures. Slave results arrive about three cycles after each external edge because of the synchroniser and the edge detector. The bench holds every external level for eight cycles and checks flags only after a quiet margin. The bench's receiver model reconstructs each outgoing byte on the edges that R5 defines. A scoreboard queue holds the byte each transfer is expected to put on the wire and compares it when eight bits have been seen.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [2:0] {
    SRC_DIV4,
    SRC_DIV8,
    SRC_DIV16,
    SRC_DIV64,
    SRC_TMR
  } clk_src_e;

  typedef enum logic [1:0] {
    ROLE_OFF,
    ROLE_MASTER,
    ROLE_SLAVE
  } role_e;

  // Layout of the control register, bit 7 down to bit 0.
  typedef struct packed {
    logic       samp_late;
    logic       lead_launch_n;
    logic       idle_hi;
    logic [3:0] mode;
    logic       enable;
  } ctrl_t;

  typedef struct packed {
    role_e    role;
    clk_src_e src;
    logic     ss_used;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [3:0] m);
    mode_dec_t d;
    case (m)
      4'b0000: d = '{ROLE_MASTER, SRC_DIV4,  1'b0};
      4'b1010: d = '{ROLE_MASTER, SRC_DIV8,  1'b0};
      4'b0001: d = '{ROLE_MASTER, SRC_DIV16, 1'b0};
      4'b0010: d = '{ROLE_MASTER, SRC_DIV64, 1'b0};
      4'b0011: d = '{ROLE_MASTER, SRC_TMR,   1'b0};
      4'b0100: d = '{ROLE_SLAVE,  SRC_DIV4,  1'b1};
      4'b0101: d = '{ROLE_SLAVE,  SRC_DIV4,  1'b0};
      default: d = '{ROLE_OFF,    SRC_DIV4,  1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
  import spi_port_pkg::*;
#(
  parameter int HALF_MAX = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  clk_src_e src,
  input  logic     tmr_tick,
  output logic     half_tick
);

  localparam int CW = $clog2(HALF_MAX);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          tsel_q, tsel_d;

  always_comb begin
    case (src)
      SRC_DIV8:  limit = CW'(HALF_MAX / 8 - 1);
      SRC_DIV16: limit = CW'(HALF_MAX / 4 - 1);
      SRC_DIV64: limit = CW'(HALF_MAX - 1);
      default:   limit = CW'(HALF_MAX / 16 - 1);
    endcase
  end

  always_comb begin
    cnt_d     = cnt_q;
    tsel_d    = tsel_q;
    half_tick = 1'b0;
    if (!run) begin
      cnt_d  = '0;
      tsel_d = 1'b0;
    end else if (src == SRC_TMR) begin
      if (tmr_tick) begin
        tsel_d    = ~tsel_q;
        half_tick = tsel_q;
      end
    end else if (cnt_q == limit) begin
      cnt_d     = '0;
      half_tick = 1'b1;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tsel_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tsel_q <= tsel_d;
    end
  end

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          start,
  input  logic [DW-1:0] load_data,
  input  logic          abort,
  input  logic          step,
  input  logic          master,
  input  logic          cke,
  input  logic          late,
  input  logic          sdi,
  output logic [DW-1:0] rx_data,
  output logic          done,
  output logic          busy,
  output logic          toggle,
  output logic          dout
);

  localparam int NEV = 2 * DW;
  localparam int CW  = $clog2(NEV + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sr_q, sr_d;
  logic          run_q, run_d;
  logic          dout_q, dout_d;
  logic          do_samp, do_out;

  always_comb begin
    int ev, so, oo, last;
    ev   = int'(cnt_q);
    so   = (cke ? 0 : 1) + (late ? 1 : 0);
    oo   = cke ? 1 : 0;
    last = master ? NEV : NEV - 1;

    do_samp = step && (ev >= so) && (((ev - so) % 2) == 0) && ((ev - so) <= NEV - 2);
    do_out  = step && (ev >= oo) && (((ev - oo) % 2) == 0) && (ev <= NEV - 2);
    done    = step && (ev == last);
    toggle  = step && master && (ev <= NEV - 1);

    sr_d = sr_q;
    if (load)         sr_d = load_data;
    else if (do_samp) sr_d = {sr_q[DW-2:0], sdi};

    dout_d = dout_q;
    if (load)        dout_d = load_data[DW-1];
    else if (do_out) dout_d = do_samp ? sr_q[DW-2] : sr_q[DW-1];

    cnt_d = cnt_q;
    if (abort || done || start) cnt_d = '0;
    else if (step)              cnt_d = cnt_q + CW'(1);

    run_d = run_q;
    if (abort || done) run_d = 1'b0;
    else if (start)    run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      run_q  <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
      run_q  <= run_d;
      dout_q <= dout_d;
    end
  end

  assign rx_data = sr_d;
  assign busy    = run_q || (cnt_q != '0);
  assign dout    = dout_q;

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int HALF_MAX = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tmr_tick,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       ss_n
);

  localparam int DW = 8;

  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] buf_q, buf_d;
  logic          bf_q, bf_d, wcol_q, wcol_d, ov_q, ov_d;
  logic          sck_q, sck_d, sck_prev_q;
  mode_dec_t     dec;
  logic          is_master, is_slave, ss_block, ss_mode;
  logic          s_ss, s_sck, s_sdi;
  logic          half_tick, step, abort;
  logic          wr_buf, rd_buf, load, start;
  logic          busy, done, toggle, dout;
  logic [DW-1:0] rx_data;

  assign dec       = decode_mode(ctrl_q.mode);
  assign is_master = ctrl_q.enable && (dec.role == ROLE_MASTER);
  assign is_slave  = ctrl_q.enable && (dec.role == ROLE_SLAVE);
  assign ss_mode   = is_slave && dec.ss_used;

  spi_port_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ss_n, sck_in, sdi}),
    .q     ({s_ss, s_sck, s_sdi})
  );

  spi_port_clkgen #(.HALF_MAX(HALF_MAX)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (is_master && busy),
    .src       (dec.src),
    .tmr_tick  (tmr_tick),
    .half_tick (half_tick)
  );

  assign ss_block = ss_mode && s_ss;
  assign step     = is_master ? half_tick
                              : (is_slave && !ss_block && (s_sck != sck_prev_q));
  assign abort    = !(is_master || is_slave) || ss_block;

  assign wr_buf = bus_wr && (bus_addr == 2'd0);
  assign rd_buf = bus_rd && (bus_addr == 2'd0);
  assign load   = wr_buf && !busy;
  assign start  = load && is_master;

  spi_port_shifter #(.DW(DW)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .start     (start),
    .load_data (bus_wdata),
    .abort     (abort),
    .step      (step),
    .master    (is_master),
    .cke       (ctrl_q.lead_launch_n),
    .late      (is_master && ctrl_q.samp_late),
    .sdi       (is_master ? sdi : s_sdi),
    .rx_data   (rx_data),
    .done      (done),
    .busy      (busy),
    .toggle    (toggle),
    .dout      (dout)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    buf_d  = buf_q;
    bf_d   = bf_q;
    wcol_d = wcol_q;
    ov_d   = ov_q;
    if (bus_wr && (bus_addr == 2'd1)) ctrl_d = ctrl_t'(bus_wdata);
    if (bus_wr && (bus_addr == 2'd2)) begin
      wcol_d = 1'b0;
      ov_d   = 1'b0;
    end
    if (wr_buf && busy) wcol_d = 1'b1;
    if (rd_buf) bf_d = 1'b0;
    if (done) begin
      if (bf_q && !rd_buf) begin
        ov_d = 1'b1;
      end else begin
        buf_d = rx_data;
        bf_d  = 1'b1;
      end
    end
    if (is_master && busy) sck_d = toggle ? ~sck_q : sck_q;
    else                   sck_d = ctrl_q.idle_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      buf_q      <= '0;
      bf_q       <= 1'b0;
      wcol_q     <= 1'b0;
      ov_q       <= 1'b0;
      sck_q      <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      buf_q      <= buf_d;
      bf_q       <= bf_d;
      wcol_q     <= wcol_d;
      ov_q       <= ov_d;
      sck_q      <= sck_d;
      sck_prev_q <= s_sck;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = buf_q;
      2'd1:    bus_rdata = ctrl_q;
      2'd2:    bus_rdata = {5'b0, ov_q, wcol_q, bf_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign sck_out = sck_q;
  assign sck_oe  = is_master;
  assign sdo     = dout;
  assign sdo_oe  = is_master || (is_slave && !ss_block);

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       is_master,
  input logic       busy,
  input logic       done,
  input logic       bf,
  input logic       ov,
  input logic       wcol,
  input logic [7:0] buf_q,
  input logic       rd_buf,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       ss_n,
  input logic       ss_mode,
  input logic       sdo_oe,
  input logic       sck_out,
  input logic       idle_hi
);

  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(is_master && busy)) |=> (sck_out == $past(idle_hi)));

  assert_bf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> bf);

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !done) |=> !bf);

  assert_wcol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == 2'd0) && busy) |=> wcol);

  assert_ov_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bf && !rd_buf) |=> (ov && $stable(buf_q)));

  assert_sdo_float_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_mode && ss_n && $past(ss_n) && $past(ss_n, 2)) |-> !sdo_oe);

endmodule

bind spi_port spi_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .is_master (is_master),
  .busy      (busy),
  .done      (done),
  .bf        (bf_q),
  .ov        (ov_q),
  .wcol      (wcol_q),
  .buf_q     (buf_q),
  .rd_buf    (rd_buf),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .ss_n      (ss_n),
  .ss_mode   (ss_mode),
  .sdo_oe    (sdo_oe),
  .sck_out   (sck_out),
  .idle_hi   (ctrl_q.idle_hi)
);

// File: tb/spi_port_test.sv
module spi_port_test;

  logic       clk, rst_n;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       tmr_tick, sck_in, sck_out, sck_oe, sdi, sdo, sdo_oe, ss_n;
  logic       loop_en, sdi_drv;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] wire_q[$];
  logic       mon_on, mon_ckp, mon_cke, mon_drive;
  logic [7:0] mon_pat;
  int         mon_nb;

  assign sdi = loop_en ? sdo : sdi_drv;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_tick(tmr_tick), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(output logic [7:0] d);
    bus_addr = 2'd2;
    #1 d = bus_rdata;
  endtask

  task automatic cfg(input logic en, input logic [3:0] m, input logic ckp,
                     input logic cke, input logic smp);
    bw(2'd1, {smp, cke, ckp, m, en});
    mon_ckp = ckp; mon_cke = cke;
  endtask

  // Wire monitor: receiver model for master transfers, scoreboard compare.
  initial begin : wire_mon
    logic       prev;
    logic [7:0] cap;
    prev = 1'b0; cap = 8'h00; mon_nb = 0;
    forever begin
      @(negedge clk);
      if (mon_on && sck_oe && (sck_out != prev)) begin
        if (sck_out != mon_ckp) begin
          if (mon_cke) begin cap = {cap[6:0], sdo}; mon_nb++; end
          if (mon_drive) begin sdi_drv = mon_pat[7]; mon_pat = mon_pat << 1; end
        end else if (!mon_cke) begin
          cap = {cap[6:0], sdo}; mon_nb++;
        end
        if (mon_nb == 8) begin
          mon_nb = 0;
          if (wire_q.size() == 0) chk("R4 wire byte without expectation", cap, -1);
          else chk("R4/R5 wire byte MSB first", cap, wire_q.pop_front());
        end
      end
      prev = sck_out;
    end
  end

  // Master transfer: checks first edge and completion timing when half > 0.
  task automatic mxfer(input logic [7:0] tx, input int half, input string tag,
                       output logic [7:0] rx);
    int n, t_first;
    logic [7:0] d;
    wire_q.push_back(tx);
    mon_nb = 0;
    bw(2'd0, tx);
    t_first = -1; n = 0;
    peek(d);
    while (!d[0] && n < 20000) begin
      if (sck_out != mon_ckp && t_first < 0) t_first = n;
      @(negedge clk); n++;
      peek(d);
    end
    if (half > 0) begin
      chk({tag, " R2 first edge delay"}, t_first, half);
      chk({tag, " R2 completion delay"}, n, 17 * half);
    end
    br(2'd0, rx);
  endtask

  task automatic pulse();
    @(negedge clk); tmr_tick = 1'b1;
    @(negedge clk); tmr_tick = 1'b0;
  endtask

  // Bench acts as external master; returns the byte seen on sdo.
  task automatic sxfer(input logic [7:0] tx, input logic ckp, input logic cke,
                       input logic use_ss, output logic [7:0] cap);
    cap = 8'h00;
    if (use_ss) ss_n = 1'b0;
    sdi_drv = cke ? tx[7] : 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (cke) cap = {cap[6:0], sdo};
      sck_in = ~ckp;
      if (!cke) sdi_drv = tx[7-i];
      repeat (8) @(negedge clk);
      if (!cke) cap = {cap[6:0], sdo};
      sck_in = ckp;
      if (cke && i < 7) sdi_drv = tx[6-i];
      repeat (8) @(negedge clk);
    end
    if (use_ss) ss_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [7:0] d, cap;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    tmr_tick = 1'b0; sck_in = 1'b0; ss_n = 1'b1; loop_en = 1'b1; sdi_drv = 1'b0;
    mon_on = 1'b0; mon_ckp = 1'b0; mon_cke = 1'b0; mon_drive = 1'b0; mon_pat = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R1, R12)
    br(2'd1, d); chk("R1 control reset", d, 8'h00);
    br(2'd2, d); chk("R1 status reset", d, 8'h00);
    chk("R12 clock not driven after reset", sck_oe, 0);
    chk("R12 data not driven after reset", sdo_oe, 0);

    // R1 control readback
    cfg(1'b1, 4'b0000, 1'b0, 1'b1, 1'b0);
    br(2'd1, d); chk("R1 control readback", d, 8'b0100_0001);
    chk("R12 master drives clock", sck_oe, 1);

    // Master divider timing (R2) with loopback (R4)
    mon_on = 1'b1;
    mxfer(8'hA5, 2, "div4", d);   chk("R4 loopback div4", d, 8'hA5);
    br(2'd2, d); chk("R7 read clears buffer full", d[0], 0);
    cfg(1'b1, 4'b1010, 1'b0, 1'b1, 1'b0);
    mxfer(8'h3C, 4, "div8", d);   chk("R4 loopback div8", d, 8'h3C);
    cfg(1'b1, 4'b0001, 1'b0, 1'b1, 1'b0);
    mxfer(8'h81, 8, "div16", d);  chk("R4 loopback div16", d, 8'h81);
    cfg(1'b1, 4'b0010, 1'b0, 1'b1, 1'b0);
    mxfer(8'h5E, 32, "div64", d); chk("R4 loopback div64", d, 8'h5E);

    // Four clock modes (R5)
    for (int m = 0; m < 4; m++) begin
      logic ckp, cke;
      ckp = m[1]; cke = m[0];
      cfg(1'b1, 4'b0000, ckp, cke, 1'b0);
      repeat (2) @(negedge clk);
      chk("R5 idle clock level", sck_out, ckp);
      mxfer(8'h96 ^ 8'(m * 17), 2, "mode", d);
      chk("R5 loopback per mode", d, 8'h96 ^ 8'(m * 17));
    end

    // Sample point (R6): bench slave changes data at leading edges
    loop_en = 1'b0; mon_drive = 1'b1;
    cfg(1'b1, 4'b0000, 1'b0, 1'b1, 1'b0);
    sdi_drv = 1'b0; mon_pat = 8'hC9;
    mxfer(8'h0F, 2, "smp0", d); chk("R6 middle sample", d, 8'h64);
    cfg(1'b1, 4'b0000, 1'b0, 1'b1, 1'b1);
    sdi_drv = 1'b0; mon_pat = 8'hC9;
    mxfer(8'hF0, 2, "smp1", d); chk("R6 end sample", d, 8'hC9);
    loop_en = 1'b1; mon_drive = 1'b0;

    // Timer clock source (R3)
    cfg(1'b1, 4'b0011, 1'b0, 1'b1, 1'b0);
    wire_q.push_back(8'h6B); mon_nb = 0;
    bw(2'd0, 8'h6B);
    repeat (40) @(negedge clk);
    chk("R3 no edge without ticks", sck_out, 0);
    pulse();
    chk("R3 no edge after one tick", sck_out, 0);
    pulse();
    chk("R3 edge after second tick", sck_out, 1);
    repeat (31) pulse();
    peek(d); chk("R3 not done after 33 ticks", d[0], 0);
    pulse();
    peek(d); chk("R3 done after 34 ticks", d[0], 1);
    br(2'd0, d); chk("R3 loopback timer", d, 8'h6B);

    // Write collision (R8)
    cfg(1'b1, 4'b0001, 1'b0, 1'b1, 1'b0);
    wire_q.push_back(8'h4D); mon_nb = 0;
    bw(2'd0, 8'h4D);
    repeat (20) @(negedge clk);
    bw(2'd0, 8'hFF);
    peek(d); chk("R8 collision flag", d[1], 1);
    repeat (200) @(negedge clk);
    br(2'd0, d); chk("R8 colliding write ignored", d, 8'h4D);
    bw(2'd2, 8'h00);
    peek(d); chk("R1 status write clears collision", d[1], 0);

    // Overflow (R9)
    cfg(1'b1, 4'b0000, 1'b0, 1'b1, 1'b0);
    wire_q.push_back(8'h11); mon_nb = 0;
    bw(2'd0, 8'h11);
    repeat (50) @(negedge clk);
    wire_q.push_back(8'h22); mon_nb = 0;
    bw(2'd0, 8'h22);
    repeat (50) @(negedge clk);
    peek(d); chk("R9 overflow and full", d[2:0], 3'b101);
    br(2'd0, d); chk("R9 unread byte kept", d, 8'h11);
    bw(2'd2, 8'h00);
    peek(d); chk("R9 status cleared", d[2:0], 3'b000);
    mon_on = 1'b0;
    chk("R4 scoreboard drained", wire_q.size(), 0);

    // Slave, select honoured, launch before leading edge (R10)
    loop_en = 1'b0;
    cfg(1'b0, 4'b0000, 1'b0, 1'b1, 1'b0);
    sck_in = 1'b0;
    repeat (4) @(negedge clk);
    cfg(1'b1, 4'b0100, 1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R11 output released while select high", sdo_oe, 0);
    bw(2'd0, 8'h5A);
    sxfer(8'h96, 1'b0, 1'b1, 1'b1, cap);
    chk("R10 slave sends byte", cap, 8'h5A);
    br(2'd0, d); chk("R10 slave receives byte", d, 8'h96);

    // Select high: clock ignored (R11)
    for (int i = 0; i < 16; i++) begin
      sck_in = ~sck_in;
      repeat (8) @(negedge clk);
    end
    peek(d); chk("R11 clock ignored while select high", d[0], 0);
    chk("R11 output still released", sdo_oe, 0);

    // Slave, select ignored, idle high, launch at leading edge (R10, R11)
    cfg(1'b0, 4'b0000, 1'b1, 1'b0, 1'b0);
    sck_in = 1'b1;
    repeat (4) @(negedge clk);
    cfg(1'b1, 4'b0101, 1'b1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R11 output driven when select ignored", sdo_oe, 1);
    bw(2'd0, 8'hC3);
    sxfer(8'h2E, 1'b1, 1'b0, 1'b0, cap);
    chk("R10 slave sends byte mode 0101", cap, 8'hC3);
    br(2'd0, d); chk("R10 slave receives byte mode 0101", d, 8'h2E);

    // Disabled and reserved codes (R12)
    cfg(1'b0, 4'b0000, 1'b0, 1'b1, 1'b0);
    bw(2'd0, 8'h77);
    repeat (100) @(negedge clk);
    peek(d); chk("R12 disabled write starts nothing", d[0], 0);
    chk("R12 disabled clock released", sck_oe, 0);
    cfg(1'b1, 4'b0110, 1'b0, 1'b1, 1'b0);
    bw(2'd0, 8'h78);
    repeat (100) @(negedge clk);
    peek(d); chk("R12 reserved code starts nothing", d[0], 0);
    chk("R12 reserved code data released", sdo_oe, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule